// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single management transactions towards an Ethernet PHY. A host raises a one-cycle start request together with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then generates the management clock from the system clock with a fixed divider. It shifts the whole frame out on the data line and releases the line when the PHY must talk. On reads it collects the PHY's 16 answer bits.

The data line is split into an output, an output enable and an input, so a pad or a testbench can close the bidirectional line. While a frame runs, a busy flag is high. When the frame's last clock has finished, busy drops and a one-cycle done pulse appears. For a read, the captured register value is already on the read-data port at that moment.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy, done, mdc and mdio_oe are low and rdata is zero.
- R2: While a frame runs, each mdc period lasts CLK_DIV system clocks. The low phase (CLK_DIV/2 clocks) comes first and the high phase (the remaining clocks) follows.
- R3: Every frame starts with these fields, all driven (mdio_oe high) and sampled at mdc rising edges: 32 ones, start code 0 then 1, opcode (write 0 then 1, read 1 then 0), PHY address MSB first, register address MSB first.
- R4: A write frame then drives turnaround 1 then 0 and the 16 write-data bits MSB first, and ends with one mdc pulse with the line released, giving 65 pulses in total.
- R5: A read frame releases the line for one turnaround pulse, 16 data pulses and one trailing pulse, giving 64 pulses in total.
- R6: On a read, mdio_i is sampled one system clock after the falling mdc edge that ends each data bit. The bits are assembled MSB first and appear on rdata together with done. A write leaves rdata unchanged.
- R7: busy rises in the cycle after an accepted start and stays high for exactly pulses × CLK_DIV cycles. done is high for one cycle: the first cycle with busy low.
- R8: A start request while busy is ignored. The running frame is unaffected and no second frame follows.
- R9: Whenever busy is low, mdc is low and mdio_oe is low.
- R10: mdio_o and mdio_oe change only while mdc is low, so each driven bit is set up before the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle transaction request |
| rd_sel | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr | input | PHY_AW | Target PHY address |
| reg_addr | input | REG_AW | Target register address |
| wdata | input | DATA_W | Data for write frames |
| rdata | output | DATA_W | Captured read data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data line as seen by the block |

## Verification
The bench mixes random reads and writes, with random addresses and data, against directed extremes. The directed cases are all-zero and all-one data, alternating bit patterns, and address 31 against address 0. These catch bit-order and field-position errors that a single value would mask. A small PHY model answers reads, so a wrong sampling point shows up as a shifted or corrupted read value. A start pulse injected mid-frame with a different opcode and address separates a design that ignores it from one that restarts or relatches. Pulse counts and busy lengths separate the 64-pulse read frame from the 65-pulse write frame.

// File: rtl/mdio_pkg.sv
// Package: shared constants and field-length helpers for the management
// frame master. Assumes clause-22 framing with a fixed two-bit start code.
package mdio_pkg;

    localparam logic [1:0] ST_CODE = 2'b01;
    localparam logic [1:0] OPC_WR  = 2'b01;
    localparam logic [1:0] OPC_RD  = 2'b10;
    localparam logic [1:0] TA_WR   = 2'b10;

    // Bits before the turnaround: preamble, start, opcode, two addresses
    function automatic int head_bits(input int pre, input int pa, input int ra);
        return pre + 4 + pa + ra;
    endfunction

    // Total mdc pulses of a write frame (driven part plus one release)
    function automatic int wr_bits(input int pre, input int pa, input int ra, input int dw);
        return head_bits(pre, pa, ra) + 2 + dw + 1;
    endfunction

    // Total mdc pulses of a read frame (turnaround, data, trailing release)
    function automatic int rd_bits(input int pre, input int pa, input int ra, input int dw);
        return head_bits(pre, pa, ra) + 1 + dw + 1;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
// Module: management clock generator. While run is high it divides clk by
// CLK_DIV, low phase first, and flags the first and last system cycle of
// every bit period. Assumes CLK_DIV >= 4. mdc is low whenever run is low.
module mdio_mdc_gen #(
    parameter int CLK_DIV = 102
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic bit_first,
    output logic bit_last
);
    localparam int CW = $clog2(CLK_DIV);
    localparam int HALF = CLK_DIV / 2;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
    localparam logic [CW:0] HALF_V = (CW+1)'(HALF);

    logic [CW-1:0] cnt;
    logic [CW:0]   cnt_inc;

    assign cnt_inc   = {1'b0, cnt} + 1'b1;
    assign bit_first = run && (cnt == '0);
    assign bit_last  = run && (cnt == LAST);

    // Divider counter and registered clock level for the next count value
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= (cnt == LAST) ? '0 : cnt_inc[CW-1:0];
            mdc <= (cnt != LAST) && (cnt_inc >= HALF_V);
        end
    end
endmodule

// File: rtl/mdio_frame_ctl.sv
// Module: frame sequencer. Accepts a start while idle, loads the complete
// outgoing bit pattern into a shift register, advances one bit per mdc
// period and decides when the line is driven. Assumes bit_last comes from
// the clock generator running off this module's busy.
module mdio_frame_ctl
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = 32,
    parameter int PHY_AW   = 5,
    parameter int REG_AW   = 5,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_sel,
    input  logic [PHY_AW-1:0] phy_addr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bit_last,
    output logic              busy,
    output logic              is_rd,
    output logic [$clog2(wr_bits(PRE_BITS, PHY_AW, REG_AW, DATA_W)+1)-1:0] idx,
    output logic              frame_end,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int HEAD = head_bits(PRE_BITS, PHY_AW, REG_AW);
    localparam int TX_W = HEAD + 2 + DATA_W;
    localparam int WR_N = wr_bits(PRE_BITS, PHY_AW, REG_AW, DATA_W);
    localparam int RD_N = rd_bits(PRE_BITS, PHY_AW, REG_AW, DATA_W);
    localparam int IW   = $clog2(WR_N + 1);
    localparam logic [IW-1:0] WR_LAST = IW'(WR_N - 1);
    localparam logic [IW-1:0] RD_LAST = IW'(RD_N - 1);
    localparam logic [IW-1:0] WR_DRV  = IW'(TX_W);
    localparam logic [IW-1:0] RD_DRV  = IW'(HEAD);

    logic [TX_W-1:0] tx_sr;
    logic            drive;

    assign frame_end = busy && bit_last && (idx == (is_rd ? RD_LAST : WR_LAST));
    assign drive     = busy && (idx < (is_rd ? RD_DRV : WR_DRV));
    assign mdio_oe   = drive;
    assign mdio_o    = drive && tx_sr[TX_W-1];

    // Accept a request when idle, then step through the frame one bit per mdc period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            is_rd <= 1'b0;
            idx   <= '0;
            tx_sr <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                is_rd <= rd_sel;
                idx   <= '0;
                tx_sr <= {{PRE_BITS{1'b1}}, ST_CODE, (rd_sel ? OPC_RD : OPC_WR),
                          phy_addr, reg_addr, TA_WR, wdata};
            end
        end else if (bit_last) begin
            if (frame_end) begin
                busy <= 1'b0;
            end else begin
                idx   <= idx + 1'b1;
                tx_sr <= {tx_sr[TX_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/mdio_rd_capture.sv
// Module: read-data capture. Samples the line in the first system cycle of
// the bit period after each read data bit (just past the falling mdc edge),
// shifts MSB first, and publishes the word with a one-cycle done pulse.
// Assumes idx counts bit periods from zero as in the frame sequencer.
module mdio_rd_capture
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = 32,
    parameter int PHY_AW   = 5,
    parameter int REG_AW   = 5,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              is_rd,
    input  logic              bit_first,
    input  logic [$clog2(wr_bits(PRE_BITS, PHY_AW, REG_AW, DATA_W)+1)-1:0] idx,
    input  logic              frame_end,
    input  logic              mdio_i,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);
    localparam int HEAD = head_bits(PRE_BITS, PHY_AW, REG_AW);
    localparam int IW   = $clog2(wr_bits(PRE_BITS, PHY_AW, REG_AW, DATA_W) + 1);
    localparam logic [IW-1:0] CAP_LO = IW'(HEAD + 2);
    localparam logic [IW-1:0] CAP_HI = IW'(HEAD + 1 + DATA_W);

    logic [DATA_W-1:0] rx_sr;
    logic              cap;

    assign cap = busy && is_rd && bit_first && (idx >= CAP_LO) && (idx <= CAP_HI);

    // Shift in one answer bit per data period of a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (cap) begin
            rx_sr <= {rx_sr[DATA_W-2:0], mdio_i};
        end
    end

    // Publish the word and pulse done when the frame's last period ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            done <= frame_end;
            if (frame_end && is_rd) begin
                rdata <= rx_sr;
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
// Module: top of the management frame master. Ties the clock generator,
// frame sequencer and read capture together. Assumes the host holds its
// request fields valid in the cycle start is high; start while busy is dropped.
module mdio_master #(
    parameter int CLK_DIV  = 102,
    parameter int PRE_BITS = 32,
    parameter int PHY_AW   = 5,
    parameter int REG_AW   = 5,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_sel,
    input  logic [PHY_AW-1:0] phy_addr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic              done,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int IW = $clog2(mdio_pkg::wr_bits(PRE_BITS, PHY_AW, REG_AW, DATA_W) + 1);

    logic          bit_first;
    logic          bit_last;
    logic          is_rd;
    logic          frame_end;
    logic [IW-1:0] idx;

    mdio_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .mdc       (mdc),
        .bit_first (bit_first),
        .bit_last  (bit_last)
    );

    mdio_frame_ctl #(
        .PRE_BITS (PRE_BITS),
        .PHY_AW   (PHY_AW),
        .REG_AW   (REG_AW),
        .DATA_W   (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rd_sel    (rd_sel),
        .phy_addr  (phy_addr),
        .reg_addr  (reg_addr),
        .wdata     (wdata),
        .bit_last  (bit_last),
        .busy      (busy),
        .is_rd     (is_rd),
        .idx       (idx),
        .frame_end (frame_end),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    mdio_rd_capture #(
        .PRE_BITS (PRE_BITS),
        .PHY_AW   (PHY_AW),
        .REG_AW   (REG_AW),
        .DATA_W   (DATA_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .is_rd     (is_rd),
        .bit_first (bit_first),
        .idx       (idx),
        .frame_end (frame_end),
        .mdio_i    (mdio_i),
        .rdata     (rdata),
        .done      (done)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Module: protocol checker for the management frame master, bound to every
// instance. Watches only top-level ports and keeps its own pulse counter.
module mdio_master_chk #(
    parameter int CLK_DIV  = 102,
    parameter int PRE_BITS = 32,
    parameter int PHY_AW   = 5,
    parameter int REG_AW   = 5,
    parameter int DATA_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              rd_sel,
    input logic [DATA_W-1:0] rdata,
    input logic              busy,
    input logic              done,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe
);
    localparam int WR_N = mdio_pkg::wr_bits(PRE_BITS, PHY_AW, REG_AW, DATA_W);
    localparam int RD_N = mdio_pkg::rd_bits(PRE_BITS, PHY_AW, REG_AW, DATA_W);

    logic [7:0] pulses;
    logic       mdc_d;
    logic       rd_q;

    // Count mdc rising edges per frame and remember the frame type
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulses <= '0;
            mdc_d  <= 1'b0;
            rd_q   <= 1'b0;
        end else begin
            mdc_d <= mdc;
            if (start && !busy) begin
                pulses <= '0;
                rd_q   <= rd_sel;
            end else if (mdc && !mdc_d) begin
                pulses <= pulses + 1'b1;
            end
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy && !done && !mdc && !mdio_oe && rdata == '0));

    a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    a_r10_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    a_r7_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(start) && !$past(busy)));

    a_r8_keep_running: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R4 and R5: pulse total per frame type
    a_r5_pulse_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pulses == (rd_q ? 8'(RD_N) : 8'(WR_N))));
endmodule

bind mdio_master mdio_master_chk #(
    .CLK_DIV  (CLK_DIV),
    .PRE_BITS (PRE_BITS),
    .PHY_AW   (PHY_AW),
    .REG_AW   (REG_AW),
    .DATA_W   (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .rd_sel  (rd_sel),
    .rdata   (rdata),
    .busy    (busy),
    .done    (done),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
    localparam int DIV  = 10;
    localparam int HEAD = 46;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_sel = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mdio_master #(.CLK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_sel(rd_sel),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
        .rdata(rdata), .busy(busy), .done(done), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // Frame recording and PHY model state
    logic rec_o  [0:127];
    logic rec_oe [0:127];
    int   rises = 0;
    int   cyc = 0, last_rise = 0, hi_cnt = 0;
    bit   per_err = 0, stab_err = 0, idle_err = 0;
    logic mdc_p = 0, o_p = 0, oe_p = 0;
    bit   phy_rd = 0;
    logic [15:0] phy_val = '0;

    task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Expected {oe, o} at mdc rising edge k
    function automatic logic [1:0] exp_bit(input bit rd, input logic [4:0] pa,
                                           input logic [4:0] ra, input logic [15:0] wd, input int k);
        if (k < 32)  return 2'b11;
        if (k == 32) return 2'b10;
        if (k == 33) return 2'b11;
        if (k == 34) return {1'b1, rd};
        if (k == 35) return {1'b1, ~rd};
        if (k < 41)  return {1'b1, pa[40-k]};
        if (k < 46)  return {1'b1, ra[45-k]};
        if (rd) return 2'b00;
        if (k == 46) return 2'b11;
        if (k == 47) return 2'b10;
        if (k < 64)  return {1'b1, wd[63-k]};
        return 2'b00;
    endfunction

    // Monitor at the falling system edge: record bits, timing, stability, PHY answer
    always @(negedge clk) begin
        cyc++;
        if (mdc && !mdc_p) begin
            if (rises > 0 && (cyc - last_rise) != DIV) per_err = 1;
            last_rise = cyc;
            if (rises < 128) begin
                rec_o[rises]  = mdio_o;
                rec_oe[rises] = mdio_oe;
            end
            if (phy_rd && rises >= HEAD + 1 && rises <= HEAD + 16)
                mdio_i = phy_val[HEAD + 16 - rises];
            else
                mdio_i = 1'b1;
            rises++;
        end
        if (mdc) hi_cnt++;
        if (mdc_p && !mdc) begin
            if (hi_cnt != DIV - DIV / 2) per_err = 1;
            hi_cnt = 0;
        end
        if (mdc && mdc_p && (mdio_o !== o_p || mdio_oe !== oe_p)) stab_err = 1;
        if (rst_n && !busy && (mdc || mdio_oe)) idle_err = 1;
        mdc_p = mdc; o_p = mdio_o; oe_p = mdio_oe;
    end

    logic [15:0] prev_rdata = '0;

    task automatic run_txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] rv, input bit inject);
        int bc;
        int nbits;
        int head_bad;
        int tail_bad;
        nbits = rd ? 64 : 65;
        phy_rd = rd; phy_val = rv;
        rises = 0; per_err = 0; stab_err = 0;
        @(negedge clk);
        start = 1'b1; rd_sel = rd; phy_addr = pa; reg_addr = ra; wdata = wd;
        @(negedge clk);
        start = 1'b0; rd_sel = ~rd; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd;
        check(busy === 1'b1, "R7 busy after start", 64'(busy), 64'd1);
        bc = 0;
        while (busy === 1'b1 && bc < 2000) begin
            start = (inject && bc == 3 * DIV) ? 1'b1 : 1'b0;
            bc++;
            @(negedge clk);
        end
        start = 1'b0;
        check(bc == nbits * DIV, "R7 busy length", 64'(bc), 64'(nbits * DIV));
        check(done === 1'b1, "R7 done at busy fall", 64'(done), 64'd1);
        if (rd) check(rdata === rv, "R6 read data", 64'(rdata), 64'(rv));
        else    check(rdata === prev_rdata, "R6 rdata kept on write", 64'(rdata), 64'(prev_rdata));
        check(rises == nbits, rd ? "R5 read pulse count" : "R4 write pulse count", 64'(rises), 64'(nbits));
        head_bad = 0; tail_bad = 0;
        for (int k = 0; k < nbits && k < 128; k++) begin
            logic [1:0] e;
            e = exp_bit(rd, pa, ra, wd, k);
            if (rec_oe[k] !== e[1] || (e[1] && rec_o[k] !== e[0])) begin
                if (k < HEAD) head_bad++; else tail_bad++;
            end
        end
        check(head_bad == 0, "R3 frame head bits", 64'(head_bad), 64'd0);
        check(tail_bad == 0, rd ? "R5 read release pattern" : "R4 write tail bits", 64'(tail_bad), 64'd0);
        check(!per_err, "R2 mdc period and phases", 64'(per_err), 64'd0);
        check(!stab_err, "R10 line stable while mdc high", 64'(stab_err), 64'd0);
        @(negedge clk);
        check(done === 1'b0, "R7 done single cycle", 64'(done), 64'd0);
        if (inject) begin
            bc = 0;
            for (int i = 0; i < 3 * DIV; i++) begin
                if (busy !== 1'b0) bc++;
                @(negedge clk);
            end
            check(bc == 0, "R8 no frame after ignored start", 64'(bc), 64'd0);
        end
        prev_rdata = rdata;
    endtask

    initial begin
        void'($urandom(32'h0BAD5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mdc && !mdio_oe && rdata == 16'h0, "R1 reset state",
              {busy, done, mdc, mdio_oe, rdata}, 64'd0);
        // Directed corner cases
        run_txn(1'b0, 5'd31, 5'd0,  16'h0000, 16'h0000, 1'b0);
        run_txn(1'b1, 5'd0,  5'd31, 16'h0000, 16'hFFFF, 1'b0);
        run_txn(1'b0, 5'd21, 5'd10, 16'hFFFF, 16'h0000, 1'b0);
        run_txn(1'b1, 5'd10, 5'd21, 16'h0000, 16'hA5C3, 1'b0);
        run_txn(1'b1, 5'd3,  5'd17, 16'h0000, 16'h0001, 1'b1);
        run_txn(1'b0, 5'd17, 5'd3,  16'h8000, 16'h0000, 1'b1);
        // Random mix
        for (int t = 0; t < 14; t++) begin
            logic [31:0] r;
            r = $urandom;
            run_txn(r[0], r[5:1], r[10:6], r[26:11], 16'($urandom), r[27] & r[28]);
        end
        check(!idle_err, "R9 idle mdc low and line released", 64'(idle_err), 64'd0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule